// File: doc/BRIEF.md
# Asynchronous Static RAM Write Sequencer

This block turns single-word write requests from on-chip logic into correctly timed write cycles on an external asynchronous static RAM with 256K sixteen-bit words. A request carries an 18-bit word address, 16 bits of data and a two-bit lane enable. It is taken in over a valid/ready handshake. The block then runs a fixed sequence of phases, each a whole number of system-clock cycles, on the memory pins: two chip selects of opposite polarity, an active-low write strobe, one active-low strobe per byte lane, the address bus, and the data bus. The data bus is presented as a pad-ready pair: an output value and an output enable. A pad cell outside the block forms the three-state driver.

A memory write happens only while all of the following hold: the active-low select is low, the active-high select is high, the write strobe is low, and at least one lane strobe is low. The window opens when the last of these becomes true and closes when the first becomes false.

The sequencer drives the address, the selects and the lane strobes in a setup phase. It then lowers the write strobe for the write phase. At the end of the write phase it releases every control pin on the same clock edge. A recovery phase follows, in which address and data are still driven. The recovery phase is lengthened when needed so that the whole cycle meets a minimum length. With the defaults and a 100 MHz clock, a cycle has 1 setup cycle, 5 write cycles and 1 recovery cycle, 70 ns in total. That gives 60 ns of address, select and lane-strobe validity, 50 ns of write strobe and 60 ns of data before the window closes.

Top module: `sram_wr_ctrl`

## Requirements
- R1: While reset is held and on the first cycle after it, ready is 1, the active-low select is 1, the active-high select is 0, the write strobe and both lane strobes are 1, and the data output enable is 0. A reset taken in the middle of a cycle returns the pins to this state one edge later.
- R2: A request is accepted on a rising edge where valid and ready are both 1. Ready stays 0 from the next cycle until the cycle has fully finished. Requests presented while ready is 0 are ignored.
- R3: For SETUP_CYC cycles starting the cycle after acceptance, the following hold: the captured address is driven, the active-low select is 0, the active-high select is 1, the write strobe is 1, and the data output enable is 1.
- R4: Directly after setup, the write strobe is 0 for exactly WE_CYC consecutive cycles, and only while both selects are active.
- R5: The lower strobe is low when lane-enable bit 0 is 1, and that strobe covers data bits 7:0. The upper strobe is low when bit 1 is 1, and it covers bits 15:8. An enabled strobe is held low through both the setup and write phases.
- R6: At the end of the write phase, both selects, the write strobe and both lane strobes go inactive on the same edge. During the recovery phase every control is inactive.
- R7: The address and the data output keep their captured values from setup to the end of recovery, whatever the request inputs do in that time.
- R8: The data output enable is 1 only from the first setup cycle through the last recovery cycle, and 0 at all other times.
- R9: A lane enable of 2'b00 runs a cycle of full length in which neither lane strobe goes low.
- R10: A cycle lasts max(SETUP_CYC+WE_CYC+REC_CYC, MIN_CYC) cycles. When the sum falls short, the extra cycles are added to the recovery phase.
- R11: Ready returns to 1 on the first cycle after recovery, so a request held valid is accepted on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Write request present |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_addr | input | 18 | Word address of the request |
| req_data | input | 16 | Write data of the request |
| req_be | input | 2 | Lane enables, bit 0 lower byte, bit 1 upper byte |
| sram_addr | output | 18 | Memory address bus |
| sram_dq_o | output | 16 | Data value for the pad driver |
| sram_dq_oe | output | 1 | Pad driver enable, 0 means high impedance |
| sram_cs1_n | output | 1 | Chip select, active low |
| sram_cs2 | output | 1 | Chip select, active high |
| sram_we_n | output | 1 | Write strobe, active low |
| sram_lb_n | output | 1 | Lower lane strobe, active low |
| sram_ub_n | output | 1 | Upper lane strobe, active low |

## Verification
The bench compares every pin, cycle by cycle, across whole write cycles for each lane-enable value, including the all-ones address and the 2'b00 case. A design that let a lane strobe through for 2'b00 would create a write that should not happen. It keeps valid high with changing data while the sequencer is busy; a design that re-captured, or accepted early, would shift the address or data in the middle of the window. A second instance with a raised minimum cycle length shows whether the recovery phase is padded, as opposed to the write pulse being stretched or the cycle left short. A reset taken during the write phase must drop every strobe on the next edge; a design that did not would leave a write window open across reset.

// File: rtl/sram_wr_pkg.sv
// Package: shared phase encoding for the static RAM write sequencer.
// Assumes: one phase register in the top; phases run in declaration order.
package sram_wr_pkg;
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_SETUP = 2'd1,
        PH_WRITE = 2'd2,
        PH_RECOV = 2'd3
    } phase_e;
endpackage

// File: rtl/sram_wr_timer.sv
// Module: down-counting phase timer. Loading value N makes done rise N cycles later.
// Assumes: load is pulsed on the edge that enters a phase; counter idles at zero.
module sram_wr_timer #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);
    logic [CNT_W-1:0] cnt_q;

    // Purpose: load on phase entry, otherwise count down to zero and stay there.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = (cnt_q == '0);

    // R10: the counter never rises by itself; it only moves up when it is loaded.
    a_r10_timer_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(load) && $past(rst_n) |-> cnt_q <= $past(cnt_q));
endmodule

// File: rtl/sram_wr_pins.sv
// Module: captures the request and registers every memory pin from the next phase.
// Assumes: load is asserted only on the accepting edge; two byte lanes.
module sram_wr_pins
    import sram_wr_pkg::*;
#(
    parameter int ADDR_W = 18,
    parameter int DATA_W = 16,
    parameter int BE_W   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_data,
    input  logic [BE_W-1:0]   req_be,
    input  phase_e            phase_nxt,
    output logic [ADDR_W-1:0] sram_addr,
    output logic [DATA_W-1:0] sram_dq_o,
    output logic              sram_dq_oe,
    output logic              sram_cs1_n,
    output logic              sram_cs2,
    output logic              sram_we_n,
    output logic [BE_W-1:0]   strobe_n
);
    logic [BE_W-1:0] be_q;
    logic [BE_W-1:0] be_nxt;
    logic            sel_nxt;

    // Purpose: choose the lane enables that apply to the coming cycle.
    always_comb begin
        be_nxt  = load ? req_be : be_q;
        sel_nxt = (phase_nxt == PH_SETUP) || (phase_nxt == PH_WRITE);
    end

    // Purpose: hold the captured request fields for the whole cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sram_addr <= '0;
            sram_dq_o <= '0;
            be_q      <= '0;
        end else if (load) begin
            sram_addr <= req_addr;
            sram_dq_o <= req_data;
            be_q      <= req_be;
        end
    end

    // Purpose: glitch-free registered control pins, aligned with the phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sram_cs1_n <= 1'b1;
            sram_cs2   <= 1'b0;
            sram_we_n  <= 1'b1;
            strobe_n   <= '1;
            sram_dq_oe <= 1'b0;
        end else begin
            sram_cs1_n <= !sel_nxt;
            sram_cs2   <= sel_nxt;
            sram_we_n  <= !(phase_nxt == PH_WRITE);
            strobe_n   <= sel_nxt ? ~be_nxt : '1;
            sram_dq_oe <= (phase_nxt != PH_IDLE);
        end
    end

    // R5: a lane strobe is only ever active inside the chip-select window.
    a_r5_strobe_in_select: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_n != '1) |-> (!sram_cs1_n && sram_cs2));
    // R9: an all-zero lane enable keeps both strobes released.
    a_r9_no_strobe_zero_be: assert property (@(posedge clk) disable iff (!rst_n)
        (be_q == '0) && !$past(load) && $past(rst_n) |-> strobe_n == '1);
endmodule

// File: rtl/sram_wr_ctrl.sv
// Module: top of the static RAM write sequencer. Runs idle, setup, write and
// recovery phases with parameterised cycle counts.
// Assumes: all phase counts are at least 1; DATA_W splits into two byte lanes;
// the data pad driver outside forms the three-state bus from sram_dq_o/oe.
module sram_wr_ctrl
    import sram_wr_pkg::*;
#(
    parameter int ADDR_W    = 18,
    parameter int DATA_W    = 16,
    parameter int SETUP_CYC = 1,
    parameter int WE_CYC    = 5,
    parameter int REC_CYC   = 1,
    parameter int MIN_CYC   = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_data,
    input  logic [1:0]        req_be,
    output logic [ADDR_W-1:0] sram_addr,
    output logic [DATA_W-1:0] sram_dq_o,
    output logic              sram_dq_oe,
    output logic              sram_cs1_n,
    output logic              sram_cs2,
    output logic              sram_we_n,
    output logic              sram_lb_n,
    output logic              sram_ub_n
);
    localparam int BE_W    = 2;
    localparam int SUM_CYC = SETUP_CYC + WE_CYC + REC_CYC;
    localparam int REC_EFF = (SUM_CYC >= MIN_CYC) ? REC_CYC : (MIN_CYC - SETUP_CYC - WE_CYC);
    localparam int MAX_A   = (SETUP_CYC > WE_CYC) ? SETUP_CYC : WE_CYC;
    localparam int MAX_PH  = (MAX_A > REC_EFF) ? MAX_A : REC_EFF;
    localparam int CNT_W   = (MAX_PH > 1) ? $clog2(MAX_PH) : 1;
    localparam logic [CNT_W-1:0] LD_SETUP = CNT_W'(SETUP_CYC - 1);
    localparam logic [CNT_W-1:0] LD_WRITE = CNT_W'(WE_CYC - 1);
    localparam logic [CNT_W-1:0] LD_RECOV = CNT_W'(REC_EFF - 1);

    phase_e           phase_q, phase_d;
    logic             accept;
    logic             t_load, t_done;
    logic [CNT_W-1:0] t_val;
    logic [BE_W-1:0]  strobe_n;

    assign req_ready = (phase_q == PH_IDLE);
    assign accept    = req_valid && req_ready;

    // Purpose: next-phase decode and timer reload on every phase entry.
    always_comb begin
        phase_d = phase_q;
        t_load  = 1'b0;
        t_val   = '0;
        unique case (phase_q)
            PH_IDLE:  if (accept) begin phase_d = PH_SETUP; t_load = 1'b1; t_val = LD_SETUP; end
            PH_SETUP: if (t_done) begin phase_d = PH_WRITE; t_load = 1'b1; t_val = LD_WRITE; end
            PH_WRITE: if (t_done) begin phase_d = PH_RECOV; t_load = 1'b1; t_val = LD_RECOV; end
            PH_RECOV: if (t_done) begin phase_d = PH_IDLE; end
            default:  phase_d = PH_IDLE;
        endcase
    end

    // Purpose: phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= PH_IDLE;
        else        phase_q <= phase_d;
    end

    sram_wr_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (t_load),
        .load_val (t_val),
        .done     (t_done)
    );

    sram_wr_pins #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BE_W(BE_W)) u_pins (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (accept),
        .req_addr   (req_addr),
        .req_data   (req_data),
        .req_be     (req_be),
        .phase_nxt  (phase_d),
        .sram_addr  (sram_addr),
        .sram_dq_o  (sram_dq_o),
        .sram_dq_oe (sram_dq_oe),
        .sram_cs1_n (sram_cs1_n),
        .sram_cs2   (sram_cs2),
        .sram_we_n  (sram_we_n),
        .strobe_n   (strobe_n)
    );

    assign sram_lb_n = strobe_n[0];
    assign sram_ub_n = strobe_n[1];

    // Checker state: length of the current run of low write strobe.
    logic [7:0] we_run_q;
    always_ff @(posedge clk) begin
        if (!rst_n)         we_run_q <= '0;
        else if (sram_we_n) we_run_q <= '0;
        else if (we_run_q != 8'hFF) we_run_q <= we_run_q + 1'b1;
    end

    // R2: after acceptance the handshake is closed on the next cycle.
    a_r2_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !req_ready);
    // R4: write strobe only inside both selects.
    a_r4_we_in_select: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_we_n |-> (!sram_cs1_n && sram_cs2));
    // R4: the write pulse never exceeds its programmed width.
    a_r4_we_width: assert property (@(posedge clk) disable iff (!rst_n)
        32'(we_run_q) <= WE_CYC);
    // R6: when the write strobe rises, every other control is released on that edge too.
    a_r6_close_together: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sram_we_n) |-> (sram_cs1_n && !sram_cs2 && sram_lb_n && sram_ub_n));
    // R7: address and data stay put while the sequencer is busy.
    a_r7_fields_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_ready && !$past(req_ready) && $past(rst_n)) |-> ($stable(sram_addr) && $stable(sram_dq_o)));
    // R8: the data pad is enabled only while a cycle is running.
    a_r8_oe_busy: assert property (@(posedge clk) disable iff (!rst_n)
        sram_dq_oe |-> !req_ready);
endmodule

// File: tb/sram_wr_ctrl_tb.sv
module sram_wr_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int T_SETUP = 1;
    localparam int T_WE    = 5;
    localparam int T_REC   = 1;
    localparam int T_SLOW_MIN = 9;
    localparam int NVEC = 6;
    // {addr[17:0], data[15:0], be[1:0]}
    localparam logic [35:0] VECS [NVEC] = '{
        {18'h00000, 16'h0000, 2'b11},
        {18'h3FFFF, 16'hFFFF, 2'b11},
        {18'h12345, 16'hA55A, 2'b01},
        {18'h2ABCD, 16'h5AA5, 2'b10},
        {18'h00F0F, 16'hBEEF, 2'b00},
        {18'h1C0DE, 16'h1234, 2'b11}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        s_valid = 1'b0;
    logic [17:0] req_addr = '0;
    logic [15:0] req_data = '0;
    logic [1:0]  req_be = '0;
    logic        req_ready, s_ready;
    logic [17:0] sram_addr, s_addr;
    logic [15:0] sram_dq_o, s_dq_o;
    logic        sram_dq_oe, sram_cs1_n, sram_cs2, sram_we_n, sram_lb_n, sram_ub_n;
    logic        s_oe, s_cs1_n, s_cs2, s_we_n, s_lb_n, s_ub_n;
    int n_tests = 0;
    int n_fail  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sram_wr_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_data(req_data), .req_be(req_be),
        .sram_addr(sram_addr), .sram_dq_o(sram_dq_o), .sram_dq_oe(sram_dq_oe),
        .sram_cs1_n(sram_cs1_n), .sram_cs2(sram_cs2), .sram_we_n(sram_we_n),
        .sram_lb_n(sram_lb_n), .sram_ub_n(sram_ub_n)
    );

    sram_wr_ctrl #(.MIN_CYC(T_SLOW_MIN)) u_dut_slow (
        .clk(clk), .rst_n(rst_n), .req_valid(s_valid), .req_ready(s_ready),
        .req_addr(req_addr), .req_data(req_data), .req_be(req_be),
        .sram_addr(s_addr), .sram_dq_o(s_dq_o), .sram_dq_oe(s_oe),
        .sram_cs1_n(s_cs1_n), .sram_cs2(s_cs2), .sram_we_n(s_we_n),
        .sram_lb_n(s_lb_n), .sram_ub_n(s_ub_n)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // {cs1_n, cs2, we_n, lb_n, ub_n, oe, ready}
    function automatic logic [6:0] pins_now();
        return {sram_cs1_n, sram_cs2, sram_we_n, sram_lb_n, sram_ub_n, sram_dq_oe, req_ready};
    endfunction

    localparam logic [6:0] IDLE_PINS = 7'b1011101;

    // One full write cycle, checked pin by pin in every cycle.
    task automatic run_write(input logic [17:0] a, input logic [15:0] d, input logic [1:0] be);
        logic [6:0] exp_p;
        string tag;
        @(negedge clk);
        chk(req_ready == 1'b1, "R11 ready before request", 64'(req_ready), 64'd1);
        req_valid = 1'b1; req_addr = a; req_data = d; req_be = be;
        @(negedge clk);
        for (int k = 0; k <= T_SETUP + T_WE + T_REC; k++) begin
            if (k < T_SETUP) begin
                exp_p = {1'b0, 1'b1, 1'b1, ~be[0], ~be[1], 1'b1, 1'b0};
                tag = (be == 2'b00) ? "R9 setup" : "R3 setup";
            end else if (k < T_SETUP + T_WE) begin
                exp_p = {1'b0, 1'b1, 1'b0, ~be[0], ~be[1], 1'b1, 1'b0};
                tag = (be == 2'b00) ? "R9 write" : "R4/R5 write";
            end else if (k < T_SETUP + T_WE + T_REC) begin
                exp_p = {1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0};
                tag = "R6 recovery";
            end else begin
                exp_p = IDLE_PINS;
                tag = "R11 idle after cycle";
            end
            chk(pins_now() == exp_p, tag, 64'(pins_now()), 64'(exp_p));
            if (k < T_SETUP + T_WE + T_REC)
                chk({sram_addr, sram_dq_o} == {a, d}, "R7 fields held",
                    64'({sram_addr, sram_dq_o}), 64'({a, d}));
            // R2: keep a different request valid while busy; it must be ignored.
            req_addr = ~a; req_data = ~d; req_be = ~be;
            req_valid = (k < T_SETUP + T_WE + T_REC - 1);
            @(negedge clk);
        end
        chk({sram_addr, sram_dq_o} == {a, d}, "R2 busy request ignored",
            64'({sram_addr, sram_dq_o}), 64'({a, d}));
    endtask

    initial begin
        int busy, we_low, oe_high;
        // R1: pins while reset is held
        repeat (3) @(negedge clk);
        chk(pins_now() == IDLE_PINS, "R1 during reset", 64'(pins_now()), 64'(IDLE_PINS));
        rst_n = 1'b1;
        @(negedge clk);
        chk(pins_now() == IDLE_PINS, "R1 after reset", 64'(pins_now()), 64'(IDLE_PINS));

        for (int i = 0; i < NVEC; i++)
            run_write(VECS[i][35:18], VECS[i][17:2], VECS[i][1:0]);

        // R11: back-to-back request held valid is taken on the first idle edge
        @(negedge clk);
        req_valid = 1'b1; req_addr = 18'h01111; req_data = 16'hC0C0; req_be = 2'b11;
        repeat (T_SETUP + T_WE + T_REC + 1) @(negedge clk);
        req_addr = 18'h02222; req_data = 16'h0D0D;
        @(negedge clk);
        req_valid = 1'b0;
        chk(sram_addr == 18'h02222 && !req_ready, "R11 second request accepted",
            64'(sram_addr), 64'h02222);
        repeat (T_SETUP + T_WE + T_REC + 1) @(negedge clk);
        chk(pins_now() == IDLE_PINS, "R8 idle after back-to-back", 64'(pins_now()), 64'(IDLE_PINS));

        // R1: reset during the write phase
        req_valid = 1'b1; req_be = 2'b11;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (3) @(negedge clk);
        chk(sram_we_n == 1'b0, "R4 in write before reset", 64'(sram_we_n), 64'd0);
        rst_n = 1'b0;
        @(negedge clk);
        chk(pins_now() == IDLE_PINS, "R1 reset mid-write", 64'(pins_now()), 64'(IDLE_PINS));
        rst_n = 1'b1;
        @(negedge clk);

        // R10: slow instance pads recovery to reach MIN_CYC
        s_valid = 1'b1; req_be = 2'b01;
        @(negedge clk);
        s_valid = 1'b0;
        busy = 0; we_low = 0; oe_high = 0;
        for (int k = 0; k < 20; k++) begin
            if (!s_ready) busy++;
            if (!s_we_n) we_low++;
            if (s_oe) oe_high++;
            @(negedge clk);
        end
        chk(busy == T_SLOW_MIN, "R10 stretched cycle length", 64'(busy), 64'(T_SLOW_MIN));
        chk(we_low == T_WE, "R10 write pulse not stretched", 64'(we_low), 64'(T_WE));
        chk(oe_high == T_SLOW_MIN, "R8 oe spans stretched cycle", 64'(oe_high), 64'(T_SLOW_MIN));

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog (all requirements) actual=hung expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule